// File: doc/BRIEF.md
# Frame Buffer Write Snooper

This block listens, without ever driving the bus, to an asynchronous 16-bit CPU bus and copies every write that lands in the host's video frame buffer into a local byte-wide video SRAM. The frame buffer does not sit at a fixed address. It starts a fixed distance of 0x5900 bytes below the top of installed RAM. The amount of installed RAM is given by a 3-bit memory-size selector S, so the top of RAM is (S+1) × 512 KiB, which spans 0.5 MB to 4.0 MB. The buffer holds 512 × 342 one-bit pixels, which is 21888 bytes.

Bus control lines pass through a synchronizer into the pixel clock domain. A captured write is reduced to a 15-bit offset into the local SRAM and parked in a small queue. A byte engine then drains the queue into the SRAM one byte per cycle. It asks a display-read arbiter for the memory with a request line and writes only in cycles where the arbiter grants it. This lets scan-out reads and snooped writes share a single SRAM port.

Top module: `fbwr_snoop`

## Requirements
- R1: While reset is high and after it is released with no bus activity, `vram_ce_n` and `vram_we_n` are 1 and `arb_req` is 0.
- R2: The window base is (S+1)·0x80000 − 0x5900, where S is `mem_size`. A write whose byte address A = {`bus_addr`,0} lies in [base, base+21888) is captured. Its SRAM offset is A − base.
- R3: Writes with A below the base, or with A at or above base+21888, cause no SRAM write.
- R4: A bus cycle with `bus_rw`=1 (read) causes no SRAM write.
- R5: Each assertion of `bus_as_n` (low) yields at most one capture. The capture is taken in the first cycle where the synchronized address strobe and at least one synchronized data strobe are both low. Address, data and `bus_rw` must already be stable at that point.
- R6: With both data strobes low, two SRAM byte writes follow in order. First `bus_data[15:8]` goes to the even offset. Then `bus_data[7:0]` goes to offset+1.
- R7: With only `bus_uds_n` low, one write of `bus_data[15:8]` goes to the even offset. With only `bus_lds_n` low, one write of `bus_data[7:0]` goes to offset+1.
- R8: `arb_req` is 1 while any byte is waiting. An SRAM write (`vram_ce_n`=`vram_we_n`=0) happens only in a cycle where `arb_gnt` is 1. Each granted cycle writes at most one byte.
- R9: The queue holds up to QDEPTH (default 4) captured writes while the grant is withheld. Captures arriving while it is full are discarded. Captured writes reach the SRAM in capture order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 23 | CPU word address, bits 23:1 |
| bus_data | input | 16 | CPU write data |
| bus_as_n | input | 1 | Address strobe, active low, asynchronous |
| bus_uds_n | input | 1 | Upper (even) byte strobe, active low |
| bus_lds_n | input | 1 | Lower (odd) byte strobe, active low |
| bus_rw | input | 1 | 1 = read, 0 = write |
| mem_size | input | 3 | Installed memory selector S |
| arb_gnt | input | 1 | Arbiter grants the SRAM port this cycle |
| arb_req | output | 1 | Snooped bytes are waiting |
| vram_addr | output | 15 | SRAM byte address |
| vram_wdata | output | 8 | SRAM write data |
| vram_ce_n | output | 1 | SRAM chip enable, active low |
| vram_we_n | output | 1 | SRAM write strobe, active low |

## Verification
The hardest situation to reach is a full queue meeting further bus writes. That happens only when the display side keeps the grant away across several complete bus cycles. The stimulus holds `arb_gnt` low through five word writes and then releases it, expecting exactly the first four entries in order. Random rounds mix in-window, out-of-window and read cycles over every memory size, with random strobe combinations. One directed case drains with the grant toggling every cycle, so that a word's two byte halves are split across non-adjacent granted cycles.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    localparam int          BUS_AW     = 24;        // byte address width
    localparam int          VRAM_AW    = 15;
    localparam int          FB_BYTES   = 21888;     // 512 x 342 / 8
    localparam logic [23:0] FB_GAP     = 24'h5900;
    localparam int          BANK_SHIFT = 19;        // 512 KiB per selector step

    typedef struct packed {
        logic [VRAM_AW-1:0] offs;
        logic [15:0]        data;
        logic               hi;    // even byte present
        logic               lo;    // odd byte present
    } wr_entry_t;

    localparam int ENTRY_W = $bits(wr_entry_t);

    function automatic logic [BUS_AW-1:0] fb_base(input logic [2:0] sz);
        logic [BUS_AW-1:0] top;
        top = ({21'd0, sz} + 24'd1) << BANK_SHIFT;
        return top - FB_GAP;
    endfunction

endpackage

// File: rtl/fbs_bus_capture.sv
module fbs_bus_capture
    import fbs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [23:1] bus_addr,
    input  logic [15:0] bus_data,
    input  logic        bus_as_n,
    input  logic        bus_uds_n,
    input  logic        bus_lds_n,
    input  logic        bus_rw,
    input  logic [2:0]  mem_size,
    output logic        push,
    output wr_entry_t   push_entry
);
    localparam int NS = SYNC_STAGES;

    logic [3:0] sync_q [NS];

    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 4'hF;
        else     sync_q[0] <= {bus_as_n, bus_uds_n, bus_lds_n, bus_rw};
    end

    for (genvar g = 1; g < NS; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) sync_q[g] <= 4'hF;
            else     sync_q[g] <= sync_q[g-1];
        end
    end

    logic as_s, uds_s, lds_s, rw_s;
    assign {as_s, uds_s, lds_s, rw_s} = sync_q[NS-1];

    logic seen;
    logic trigger;
    assign trigger = !as_s && (!uds_s || !lds_s) && !seen;

    always_ff @(posedge clk) begin
        if (rst || as_s) seen <= 1'b0;
        else if (trigger) seen <= 1'b1;
    end

    logic [BUS_AW-1:0] byte_addr, base, diff;
    logic              hit;
    assign byte_addr = {bus_addr, 1'b0};
    assign base      = fb_base(mem_size);
    assign diff      = byte_addr - base;
    assign hit       = (byte_addr >= base) && (diff < 24'(FB_BYTES));

    always_ff @(posedge clk) begin
        if (rst) begin
            push       <= 1'b0;
            push_entry <= '0;
        end else begin
            push            <= trigger && !rw_s && hit;
            push_entry.offs <= diff[VRAM_AW-1:0];
            push_entry.data <= bus_data;
            push_entry.hi   <= !uds_s;
            push_entry.lo   <= !lds_s;
        end
    end

    // R5: one strobe assertion never produces back-to-back captures
    a_r5_single_capture: assert property (@(posedge clk) disable iff (rst)
        push |=> !push);
    // R5: a capture always carries at least one byte
    a_r5_has_byte: assert property (@(posedge clk) disable iff (rst)
        push |-> (push_entry.hi || push_entry.lo));

endmodule

// File: rtl/fbs_queue.sv
module fbs_queue #(
    parameter int W     = 33,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [IW-1:0] wr_idx, rd_idx;
    logic [CW-1:0] count;
    logic          full, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_idx];

    function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
        return (i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_idx] <= din;
                wr_idx      <= nxt(wr_idx);
            end
            if (do_pop) rd_idx <= nxt(rd_idx);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    a_r9_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
    a_r9_full_drop: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> full);

endmodule

// File: rtl/fbs_byte_writer.sv
module fbs_byte_writer
    import fbs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  wr_entry_t          head,
    input  logic               empty,
    input  logic               arb_gnt,
    output logic               pop,
    output logic               arb_req,
    output logic [VRAM_AW-1:0] vram_addr,
    output logic [7:0]         vram_wdata,
    output logic               vram_ce_n,
    output logic               vram_we_n
);
    logic hi_done, sel_lo, wr;

    assign sel_lo = !head.hi || hi_done;
    assign wr     = arb_gnt && !empty;
    assign pop    = wr && (sel_lo || !head.lo);

    always_ff @(posedge clk) begin
        if (rst || pop) hi_done <= 1'b0;
        else if (wr)    hi_done <= 1'b1;
    end

    assign arb_req    = !empty;
    assign vram_addr  = {head.offs[VRAM_AW-1:1], sel_lo};
    assign vram_wdata = sel_lo ? head.data[7:0] : head.data[15:8];
    assign vram_ce_n  = !wr;
    assign vram_we_n  = !wr;

    a_r8_write_needs_grant: assert property (@(posedge clk) disable iff (rst)
        !vram_we_n |-> (arb_gnt && arb_req));
    a_r8_strobes_paired: assert property (@(posedge clk) disable iff (rst)
        vram_ce_n == vram_we_n);
    a_r2_addr_in_window: assert property (@(posedge clk) disable iff (rst)
        !vram_we_n |-> (vram_addr < VRAM_AW'(FB_BYTES)));
    a_r6_odd_after_even: assert property (@(posedge clk) disable iff (rst)
        (!vram_we_n && !vram_addr[0] && head.lo) |=> (vram_we_n || vram_addr[0]));

endmodule

// File: rtl/fbwr_snoop.sv
module fbwr_snoop
    import fbs_pkg::*;
#(
    parameter int QDEPTH      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [23:1] bus_addr,
    input  logic [15:0] bus_data,
    input  logic        bus_as_n,
    input  logic        bus_uds_n,
    input  logic        bus_lds_n,
    input  logic        bus_rw,
    input  logic [2:0]  mem_size,
    input  logic        arb_gnt,
    output logic        arb_req,
    output logic [14:0] vram_addr,
    output logic [7:0]  vram_wdata,
    output logic        vram_ce_n,
    output logic        vram_we_n
);
    logic               cap_push, q_empty, q_pop;
    wr_entry_t          cap_entry, q_head;
    logic [ENTRY_W-1:0] q_head_bits;

    fbs_bus_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n),
        .bus_rw(bus_rw), .mem_size(mem_size),
        .push(cap_push), .push_entry(cap_entry)
    );

    fbs_queue #(.W(ENTRY_W), .DEPTH(QDEPTH)) u_q (
        .clk(clk), .rst(rst),
        .push(cap_push), .din(cap_entry),
        .pop(q_pop), .head(q_head_bits), .empty(q_empty)
    );

    assign q_head = wr_entry_t'(q_head_bits);

    fbs_byte_writer u_wr (
        .clk(clk), .rst(rst),
        .head(q_head), .empty(q_empty), .arb_gnt(arb_gnt),
        .pop(q_pop), .arb_req(arb_req),
        .vram_addr(vram_addr), .vram_wdata(vram_wdata),
        .vram_ce_n(vram_ce_n), .vram_we_n(vram_we_n)
    );

endmodule

// File: tb/test_fbwr_snoop.sv
module test_fbwr_snoop;
    logic        clk = 0, rst = 1;
    logic [23:1] bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic        bus_as_n = 1, bus_uds_n = 1, bus_lds_n = 1, bus_rw = 1;
    logic [2:0]  mem_size = 3'd7;
    logic        arb_gnt = 0;
    logic        arb_req, vram_ce_n, vram_we_n;
    logic [14:0] vram_addr;
    logic [7:0]  vram_wdata;

    always #2 clk = ~clk;   // 250 MHz

    fbwr_snoop i_fbwr_snoop (.*);

    int checks = 0, fails = 0;
    int exp_n = 0, obs_n = 0, pend = 0;
    logic [14:0] exp_a [64];
    logic [7:0]  exp_d [64];
    logic [14:0] obs_a [64];
    logic [7:0]  obs_d [64];
    bit done = 0;

    always @(negedge clk) begin
        if (!rst && !vram_we_n && !vram_ce_n && obs_n < 64) begin
            obs_a[obs_n] = vram_addr;
            obs_d[obs_n] = vram_wdata;
            obs_n++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic int fb_base(input int sz);
        return (sz + 1) * 32'h80000 - 32'h5900;
    endfunction

    // model of the requirements: appends expected byte writes
    task automatic model(input int sz, input int a, input logic [15:0] d,
                         input bit u, input bit l, input bit rd, input bit nodrop);
        int off;
        off = a - fb_base(sz);
        if (rd || off < 0 || off >= 21888 || !(u || l)) return;
        if (!nodrop && pend >= 4) return;
        pend++;
        if (u) begin exp_a[exp_n] = 15'(off);     exp_d[exp_n] = d[15:8]; exp_n++; end
        if (l) begin exp_a[exp_n] = 15'(off + 1); exp_d[exp_n] = d[7:0];  exp_n++; end
    endtask

    task automatic bus_cycle(input int sz, input int a, input logic [15:0] d,
                             input bit u, input bit l, input bit rd);
        @(negedge clk);
        mem_size = 3'(sz); bus_addr = a[23:1]; bus_data = d; bus_rw = rd;
        repeat (2) @(negedge clk);
        bus_as_n = 0;
        @(negedge clk);
        bus_uds_n = !u; bus_lds_n = !l;
        repeat (6) @(negedge clk);
        bus_uds_n = 1; bus_lds_n = 1; bus_as_n = 1;
        @(negedge clk);
        bus_rw = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic drain(input string req, input bit toggle);
        for (int i = 0; i < 60; i++) begin
            arb_gnt = toggle ? bit'(i[0]) : 1'b1;
            @(negedge clk);
        end
        arb_gnt = 0;
        @(negedge clk);
        check(obs_n == exp_n, req, "write count", obs_n, exp_n);
        for (int i = 0; i < exp_n && i < obs_n; i++) begin
            check(obs_a[i] == exp_a[i], req, "addr", obs_a[i], exp_a[i]);
            check(obs_d[i] == exp_d[i], req, "data", obs_d[i], exp_d[i]);
        end
        check(arb_req == 0, req, "req after drain", arb_req, 0);
        obs_n = 0; exp_n = 0; pend = 0;
    endtask

    initial begin
        int b7, b0;
        void'($urandom(32'h5eed));
        b7 = fb_base(7); b0 = fb_base(0);
        repeat (3) @(negedge clk);
        check(vram_ce_n && vram_we_n && !arb_req, "R1", "in reset",
              {vram_ce_n, vram_we_n, arb_req}, 3'b110);
        rst = 0;
        repeat (5) @(negedge clk);
        check(vram_ce_n && vram_we_n && !arb_req, "R1", "after reset",
              {vram_ce_n, vram_we_n, arb_req}, 3'b110);

        // R2/R6: word at base, 4 MB
        check(b7 == 32'h3FA700, "R2", "bench base", b7, 32'h3FA700);
        bus_cycle(7, b7, 16'hA55A, 1, 1, 0); model(7, b7, 16'hA55A, 1, 1, 0, 0);
        check(arb_req == 1 && obs_n == 0, "R8", "req held, no grant",
              {arb_req, 1'(obs_n != 0)}, 2'b10);
        drain("R6", 0);

        // R7: single strobes, 0.5 MB
        bus_cycle(0, b0 + 100, 16'h1234, 1, 0, 0); model(0, b0 + 100, 16'h1234, 1, 0, 0, 0);
        bus_cycle(0, b0 + 200, 16'h5678, 0, 1, 0); model(0, b0 + 200, 16'h5678, 0, 1, 0, 0);
        drain("R7", 0);

        // R4: read ignored
        bus_cycle(7, b7 + 10, 16'hFFFF, 1, 1, 1);
        drain("R4", 0);

        // R3: window edges
        bus_cycle(7, b7 - 2, 16'h1111, 1, 1, 0);
        bus_cycle(7, b7 + 21888, 16'h2222, 1, 1, 0);
        drain("R3", 0);
        bus_cycle(7, b7 + 21886, 16'hBEEF, 1, 1, 0); model(7, b7 + 21886, 16'hBEEF, 1, 1, 0, 0);
        drain("R2", 0);

        // R9: overflow while grant withheld
        for (int i = 0; i < 5; i++) begin
            bus_cycle(3, fb_base(3) + 2 * i, 16'(16'h0100 * i + i), 1, 1, 0);
            model(3, fb_base(3) + 2 * i, 16'(16'h0100 * i + i), 1, 1, 0, 0);
        end
        drain("R9", 0);

        // R8: toggling grant splits bytes across granted cycles
        bus_cycle(5, fb_base(5) + 40, 16'hC3A5, 1, 1, 0); model(5, fb_base(5) + 40, 16'hC3A5, 1, 1, 0, 0);
        bus_cycle(5, fb_base(5) + 42, 16'h7E81, 1, 0, 0); model(5, fb_base(5) + 42, 16'h7E81, 1, 0, 0, 0);
        drain("R8", 1);

        // R5: grant always on, one capture per strobe assertion
        arb_gnt = 1;
        bus_cycle(2, fb_base(2) + 8, 16'h9AB0, 1, 1, 0); model(2, fb_base(2) + 8, 16'h9AB0, 1, 1, 0, 1);
        repeat (10) @(negedge clk);
        check(obs_n == exp_n, "R5", "cut-through count", obs_n, exp_n);
        drain("R5", 0);

        // random rounds
        for (int r = 0; r < 25; r++) begin
            int nops;
            nops = $urandom_range(1, 3);
            for (int k = 0; k < nops; k++) begin
                int sz, kind, a, st;
                logic [15:0] d;
                bit u, l, rd;
                sz = $urandom_range(0, 7); kind = $urandom_range(0, 5);
                d = 16'($urandom); st = $urandom_range(1, 3);
                u = st[1]; l = st[0]; rd = (kind == 5);
                case (kind)
                    3:       a = fb_base(sz) - 2 * $urandom_range(1, 400);
                    4:       a = fb_base(sz) + 21888 + 2 * $urandom_range(0, 400);
                    default: a = fb_base(sz) + ($urandom_range(0, 21887) & ~1);
                endcase
                bus_cycle(sz, a, d, u, l, rd);
                model(sz, a, d, u, l, rd, 0);
            end
            drain("R2", r[0]);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule